// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

The block is a bank of eight 64-bit performance counters that software reaches through a plain 32-bit register port. Each counter has an 8-bit event code. The code picks one line out of a 128-line event vector, or it picks a special code that counts every clock. A counter advances by one on each clock in which three things hold: the global count enable is set, the counter's own enable bit is set, and its selected event is high.

When a counter rolls over from all-ones to zero, it latches a sticky status bit. The level interrupt output is high while any status bit is set and not masked. Software clears a status bit by writing a one to the clear register. The 64-bit counters are accessed as two 32-bit halves, and each half can be loaded on its own. A load takes precedence over an increment in the same cycle.

Register reads are combinational from the address. A write takes effect at the clock edge on which the write strobe is high.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, every counter, the global enable, the per-counter enables, the event codes and all status bits are zero, all eight mask bits are one, and `irq` is low.
- R2: Counter n is reached at address 0x1D00 + 8*n. Bits 31:0 are at that address and bits 63:32 are at that address + 4. Each half can be written alone, and writing one half leaves the other half unchanged.
- R3: Bit 0 of address 0x1C00 is the global count enable and reads back as bits 31:1 = 0. While it is zero, no counter changes except through a register write.
- R4: Bit n of address 0x1C14 enables counter n. A counter advances only when both its bit and the global enable are one.
- R5: Event codes are one byte per counter. Counters 0–3 take their codes from address 0x1C18 and counters 4–7 from 0x1C1C, in byte (n mod 4). A code below 128 counts cycles in which `evt_in[code]` is high. A code of 128 or above never counts.
- R6: Code 0x09 counts every enabled cycle, whatever `evt_in` holds.
- R7: A write to a counter half in a cycle where that counter would increment loads the written value and suppresses the increment.
- R8: A counter increment from all-ones to zero sets bit n of the status register at 0x0818. Software writes to 0x0818 are ignored.
- R9: Writing a one to bit n of 0x081C clears status bit n, and a zero bit leaves it unchanged. If a wrap and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: Mask register 0x0814 holds one bit per counter, where 1 masks and 0 enables. `irq` is high exactly when some status bit is set and its mask bit is zero.
- R11: Address 0x1CF0 reads the parameter `VERSION_ID` and ignores writes. Unmapped addresses and the clear register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | 16 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_in | input | 128 | Event lines, selected by the event codes |
| irq | output | 1 | Level interrupt from unmasked overflow status |

## Verification
The hardest situation to reach is a 64-bit rollover, because counting up to it from zero would take far too many cycles. The stimulus loads a counter's two halves to just below all-ones while counting is frozen, then opens the global enable for exactly two cycles, so the wrap lands on a known edge. The same preload lets a clear write be placed on the very edge where the wrap occurs, which checks that the set takes precedence. Counting windows are shaped by enable writes, so each expected count follows from the number of edges between the two writes.

// File: rtl/evb_pkg.sv
package evb_pkg;
    localparam int NUM_CNT  = 8;
    localparam int CNT_W    = 64;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 16;
    localparam int EVT_W    = 128;
    localparam int CODE_W   = 8;
    localparam int SEL_REGS = NUM_CNT * CODE_W / DATA_W;

    localparam logic [ADDR_W-1:0] A_MASK   = 16'h0814;
    localparam logic [ADDR_W-1:0] A_STATUS = 16'h0818;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 16'h081C;
    localparam logic [ADDR_W-1:0] A_CTRL   = 16'h1C00;
    localparam logic [ADDR_W-1:0] A_CNTEN  = 16'h1C14;
    localparam logic [ADDR_W-1:0] A_SEL    = 16'h1C18;
    localparam logic [ADDR_W-1:0] A_VER    = 16'h1CF0;
    localparam logic [ADDR_W-1:0] A_CNT    = 16'h1D00;

    localparam logic [CODE_W-1:0] CYCLE_CODE = 8'h09;

    typedef struct packed {
        logic                       gen;
        logic [NUM_CNT-1:0]         cnt_en;
        logic [NUM_CNT*CODE_W-1:0]  sel;
    } ctrl_t;
endpackage

// File: rtl/evb_lane.sv
module evb_lane #(
    parameter int CNT_W  = 64,
    parameter int DATA_W = 32,
    parameter int EVT_W  = 128,
    parameter int CODE_W = 8,
    parameter logic [CODE_W-1:0] CYC_CODE = 8'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic [CODE_W-1:0] code,
    input  logic [EVT_W-1:0]  evt_in,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic              wrap
);
    localparam int IDX_W = $clog2(EVT_W);
    localparam int HI_W  = CNT_W - DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } lane_t;

    lane_t st_d, st_q;
    logic  hit;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (code == CYC_CODE)
            hit = 1'b1;
        else if (int'(code) < EVT_W)
            hit = evt_in[code[IDX_W-1:0]];
        else
            hit = 1'b0;
        if (wr_lo || wr_hi) begin
            if (wr_lo) st_d.cnt[DATA_W-1:0] = wdata;
            if (wr_hi) st_d.cnt[CNT_W-1:DATA_W] = wdata[HI_W-1:0];
        end else if (count_en && hit) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap     = &st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/evb_irq.sv
module evb_irq #(
    parameter int N      = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      wrap,
    input  logic              mask_wr,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [N-1:0]      mask,
    output logic [N-1:0]      status,
    output logic              irq
);
    typedef struct packed {
        logic [N-1:0] mask;
        logic [N-1:0] status;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_wr) st_d.mask = wdata[N-1:0];
        if (clr_wr)  st_d.status = st_q.status & ~wdata[N-1:0];
        st_d.status = st_d.status | wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask   <= '1;
            st_q.status <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask   = st_q.mask;
    assign status = st_q.status;
    assign irq    = |(st_q.status & ~st_q.mask);
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
    import evb_pkg::*;
#(
    parameter logic [DATA_W-1:0] VERSION_ID = 32'h0002_0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EVT_W-1:0]  evt_in,
    output logic              irq
);
    localparam int IDX_W   = $clog2(NUM_CNT);
    localparam int CNT_SPAN = NUM_CNT * 8;

    ctrl_t ctrl_d, ctrl_q;

    logic [NUM_CNT-1:0]       wr_lo, wr_hi, wrap_v, mask_v, status_v;
    logic [NUM_CNT*CNT_W-1:0] cnt_flat;
    logic                     in_cnt;
    logic [IDX_W-1:0]         cidx;
    logic                     mask_wr, clr_wr;

    assign in_cnt  = (reg_addr >= A_CNT) && (reg_addr < A_CNT + ADDR_W'(CNT_SPAN));
    assign cidx    = reg_addr[3 +: IDX_W];
    assign mask_wr = reg_wr && (reg_addr == A_MASK);
    assign clr_wr  = reg_wr && (reg_addr == A_CLEAR);

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_wr) begin
            if (reg_addr == A_CTRL)  ctrl_d.gen    = reg_wdata[0];
            if (reg_addr == A_CNTEN) ctrl_d.cnt_en = reg_wdata[NUM_CNT-1:0];
            for (int k = 0; k < SEL_REGS; k++) begin
                if (reg_addr == A_SEL + ADDR_W'(4 * k))
                    ctrl_d.sel[k*DATA_W +: DATA_W] = reg_wdata;
            end
        end
        for (int n = 0; n < NUM_CNT; n++) begin
            wr_lo[n] = reg_wr && in_cnt && (int'(cidx) == n) && !reg_addr[2];
            wr_hi[n] = reg_wr && in_cnt && (int'(cidx) == n) &&  reg_addr[2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_lane
        evb_lane #(
            .CNT_W(CNT_W), .DATA_W(DATA_W), .EVT_W(EVT_W),
            .CODE_W(CODE_W), .CYC_CODE(CYCLE_CODE)
        ) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_en (ctrl_q.gen && ctrl_q.cnt_en[n]),
            .code     (ctrl_q.sel[n*CODE_W +: CODE_W]),
            .evt_in   (evt_in),
            .wr_lo    (wr_lo[n]),
            .wr_hi    (wr_hi[n]),
            .wdata    (reg_wdata),
            .cnt      (cnt_flat[n*CNT_W +: CNT_W]),
            .wrap     (wrap_v[n])
        );
    end

    evb_irq #(.N(NUM_CNT), .DATA_W(DATA_W)) irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap_v),
        .mask_wr (mask_wr),
        .clr_wr  (clr_wr),
        .wdata   (reg_wdata),
        .mask    (mask_v),
        .status  (status_v),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (in_cnt) begin
            reg_rdata = cnt_flat[int'(cidx)*CNT_W + (reg_addr[2] ? DATA_W : 0) +: DATA_W];
        end else begin
            case (reg_addr)
                A_CTRL:   reg_rdata = {{(DATA_W-1){1'b0}}, ctrl_q.gen};
                A_CNTEN:  reg_rdata = {{(DATA_W-NUM_CNT){1'b0}}, ctrl_q.cnt_en};
                A_MASK:   reg_rdata = {{(DATA_W-NUM_CNT){1'b0}}, mask_v};
                A_STATUS: reg_rdata = {{(DATA_W-NUM_CNT){1'b0}}, status_v};
                A_VER:    reg_rdata = VERSION_ID;
                default: begin
                    for (int k = 0; k < SEL_REGS; k++) begin
                        if (reg_addr == A_SEL + ADDR_W'(4 * k))
                            reg_rdata = ctrl_q.sel[k*DATA_W +: DATA_W];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/evb_checker.sv
module evb_checker
    import evb_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [DATA_W-1:0]        reg_wdata,
    input logic                     irq,
    input logic                     gen,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
    input logic [NUM_CNT-1:0]       wrap,
    input logic [NUM_CNT-1:0]       status,
    input logic [NUM_CNT-1:0]       mask
);
    // R1: registers leave reset with all masks set and no status
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (mask == '1 && status == '0 && !irq));

    // R3: frozen counters hold without a register write
    a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen && !reg_wr) |=> $stable(cnt_flat));

    // R8: a wrap always leaves its status bit set
    a_r8_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap != '0) |=> ((status & $past(wrap)) == $past(wrap)));

    // R9: status bits only fall through a clear write
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_CLEAR) |=> ((status & $past(status)) == $past(status)));

    // R9: cleared bits without a coincident wrap are zero afterwards
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLEAR) |=>
        ((status & $past(reg_wdata[NUM_CNT-1:0]) & ~$past(wrap)) == '0));

    // R10: the interrupt needs an unmasked status bit
    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((status & ~mask) != '0));
endmodule

bind evt_counter_bank evb_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .gen       (ctrl_q.gen),
    .cnt_flat  (cnt_flat),
    .wrap      (wrap_v),
    .status    (status_v),
    .mask      (mask_v)
);

// File: tb/evt_counter_bank_tb_top.sv
`timescale 1ns/100ps
module evt_counter_bank_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [15:0]  reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [127:0] evt_in = '0;
    logic         irq;

    localparam logic [31:0] VER = 32'h0002_0010;

    always #2.5 clk = ~clk;

    evt_counter_bank #(.VERSION_ID(VER)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;

    // monitor: compares queued expectations just after each falling edge
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it  = q.pop_front();
            got = it.is_irq ? {31'b0, irq} : reg_rdata;
            n_cmp++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    function automatic logic [15:0] cnt_a(int n, bit hi);
        return 16'h1D00 + 16'(8 * n) + (hi ? 16'd4 : 16'd0);
    endfunction

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int j);
        repeat (j) @(negedge clk);
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(16'h1C00, 32'h0, "R1 ctrl");
        rd(16'h1C14, 32'h0, "R1 enables");
        rd(16'h0814, 32'hFF, "R1 mask");
        rd(16'h0818, 32'h0, "R1 status");
        rd(cnt_a(5, 1), 32'h0, "R1 counter");
        chk_irq(1'b0, "R1 irq");

        // R11 version and unmapped space
        wr(16'h1CF0, 32'hDEAD_BEEF);
        rd(16'h1CF0, VER, "R11 version");
        rd(16'h0000, 32'h0, "R11 unmapped");
        rd(16'h081C, 32'h0, "R11 clear reads zero");

        // R2 independent halves
        wr(cnt_a(3, 0), 32'h1234_5678);
        wr(cnt_a(3, 1), 32'h9ABC_DEF0);
        rd(cnt_a(3, 0), 32'h1234_5678, "R2 low half");
        rd(cnt_a(3, 1), 32'h9ABC_DEF0, "R2 high half");
        wr(cnt_a(3, 0), 32'h0000_0001);
        rd(cnt_a(3, 1), 32'h9ABC_DEF0, "R2 high kept");
        rd(cnt_a(2, 0), 32'h0, "R2 neighbour untouched");

        // event set-up: c0=0x09, c1=0x30, c2=0x31, c3=0x09, c4=0x34, c5=0xB0, c7=0x35
        wr(16'h1C18, 32'h0931_3009);
        wr(16'h1C1C, 32'h3500_B034);
        rd(16'h1C1C, 32'h3500_B034, "R5 select readback");
        wr(16'h1C14, 32'h0000_00B7);
        evt_in[8'h30] = 1'b1;
        evt_in[8'h34] = 1'b1;
        evt_in[8'h35] = 1'b1;
        idle(4);
        rd(cnt_a(0, 0), 32'h0, "R3 no count while global off");

        // 10-cycle counting window
        wr(16'h1C00, 32'h1);
        idle(9);
        wr(16'h1C00, 32'h0);
        idle(5);
        rd(16'h1C00, 32'h0, "R3 ctrl readback");
        rd(cnt_a(0, 0), 32'd10, "R6 cycle code counts");
        rd(cnt_a(1, 0), 32'd10, "R5 code 0x30 counts");
        rd(cnt_a(2, 0), 32'd0, "R5 idle event");
        rd(cnt_a(3, 0), 32'h1, "R4 counter disabled");
        rd(cnt_a(4, 0), 32'd10, "R5 upper select byte0");
        rd(cnt_a(5, 0), 32'd0, "R5 code above 127");
        rd(cnt_a(6, 0), 32'd0, "R4 enable bit clear");
        rd(cnt_a(7, 0), 32'd10, "R5 upper select byte3");

        // R7 write beats increment
        wr(16'h1C00, 32'h1);
        wr(cnt_a(0, 0), 32'h100);
        wr(16'h1C00, 32'h0);
        rd(cnt_a(0, 0), 32'h101, "R7 write wins");
        rd(cnt_a(0, 1), 32'h0, "R7 high half");

        // R8 wrap to zero
        wr(cnt_a(7, 0), 32'hFFFF_FFFE);
        wr(cnt_a(7, 1), 32'hFFFF_FFFF);
        wr(16'h0814, 32'h7F);
        chk_irq(1'b0, "R10 no status yet");
        wr(16'h1C00, 32'h1);
        idle(1);
        wr(16'h1C00, 32'h0);
        rd(cnt_a(7, 0), 32'h0, "R8 wrapped low");
        rd(cnt_a(7, 1), 32'h0, "R8 wrapped high");
        rd(16'h0818, 32'h80, "R8 status set");
        chk_irq(1'b1, "R10 unmasked irq");
        wr(16'h0818, 32'h0);
        rd(16'h0818, 32'h80, "R8 status read-only");

        // R10 masking
        wr(16'h0814, 32'hFF);
        chk_irq(1'b0, "R10 masked");
        rd(16'h0818, 32'h80, "R10 status kept under mask");
        wr(16'h0814, 32'h7F);
        chk_irq(1'b1, "R10 unmasked again");

        // R9 write-one-to-clear
        wr(16'h081C, 32'h7F);
        rd(16'h0818, 32'h80, "R9 zero bit no effect");
        wr(16'h081C, 32'h80);
        rd(16'h0818, 32'h0, "R9 cleared");
        chk_irq(1'b0, "R9 irq dropped");

        // R9 wrap and clear on the same edge
        wr(cnt_a(7, 0), 32'hFFFF_FFFF);
        wr(cnt_a(7, 1), 32'hFFFF_FFFF);
        wr(16'h1C00, 32'h1);
        wr(16'h081C, 32'h80);
        wr(16'h1C00, 32'h0);
        rd(16'h0818, 32'h80, "R9 set beats clear");
        rd(cnt_a(7, 0), 32'h1, "R9 counter after wrap");
        chk_irq(1'b1, "R9 irq after coincident wrap");

        idle(2);
        done = 1;
        summary();
        $finish;
    end
endmodule